// File: doc/BRIEF.md
# Smart-Card Character Waiting-Time Guard

This block watches the I/O line of an ISO 7816 style smart-card interface and tells the host when the card has been silent for too long. It counts card clock cycles in coarse steps. Each step, here called a tick, lasts twelve elementary time units (ETU). A tick therefore lasts twelve times the configured clocks-per-ETU value. The configured waiting time in ETU, divided by twelve, gives the number of ticks allowed before expiry.

Every falling edge on the I/O line is a start bit, and it restarts the supervision from zero. Half-way through the allowance the block emits a one-cycle warning pulse. At the end it emits a one-cycle expiry pulse and freezes. It stays frozen until the next falling edge on the I/O line arms it again. An auxiliary waveform output marks the second half of every tick period.

The card clock enters as a one-cycle enable on the system clock, so prescaling advances only on enabled cycles. The host writes the two configuration values through simple write strobes.

Top module: `wait_guard_top`

## Requirements
- R1: After reset the guard is running with tick count and prescaler at zero, both pulses and the waveform output are low, clocks-per-ETU is 372 and the waiting time is 9600 ETU.
- R2: The prescaler advances only on cycles with `card_clk_en` high. A tick completes after clocks-per-ETU × 12 enabled cycles.
- R3: The tick target is waiting-time / 12, truncated. When the tick count reaches or passes the target, `expire_pulse` is high for exactly one cycle and `running` goes low in that same cycle.
- R4: When the tick count becomes equal to target / 2 (truncated), `half_pulse` is high for exactly one cycle. The two pulses never occur together.
- R5: `io_line` passes through a two-flop synchronizer. A high-to-low transition clears the tick count and the prescaler and sets `running`, with the effect visible after the third rising clock edge that sees the line low. A low-to-high transition has no effect.
- R6: After expiry, `running` stays low and no pulse is emitted, whatever `card_clk_en` does, until a falling edge on `io_line`.
- R7: A write to either configuration value takes effect at the next tick boundary or re-arm, whichever comes first. Until then the period in progress and the tick target in use are unchanged, and a write never clears the tick count.
- R8: A tick target of zero makes the expiry pulse fire on the first tick, with no half-way pulse.
- R9: `wave_out` rises when the prescaler reaches half of its period and falls when the period ends. It is low whenever the guard is stopped.
- R10: When a re-arming falling edge and a tick boundary fall on the same clock edge, the re-arm wins and no pulse is emitted for that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_clk_en | input | 1 | One-cycle enable per card clock period |
| io_line | input | 1 | Card I/O line, asynchronous, idles high |
| etu_wr | input | 1 | Write strobe for the clocks-per-ETU value |
| etu_wdata | input | DATA_W | Clocks per ETU |
| wt_wr | input | 1 | Write strobe for the waiting time |
| wt_wdata | input | DATA_W | Waiting time in ETU |
| half_pulse | output | 1 | One-cycle half-way warning |
| expire_pulse | output | 1 | One-cycle expiry indication |
| running | output | 1 | High while the guard is counting |
| wave_out | output | 1 | High in the second half of each tick period |

## Verification
A tick boundary is a clock edge where the prescaler completes its period on an enabled cycle. The half and expiry pulses, the drop of `running` and the fall of `wave_out` all appear on the outputs right after that same edge. A falling edge on `io_line` takes effect at the third rising edge after the line is first seen low. The bench runs a cycle-level model of these rules, updated after each rising edge from the inputs it drove. It compares all four outputs at the following falling edge, so every expected value is due at exactly the cycle where the registered output changes. Directed runs also measure the enabled-cycle distance from re-arm to each pulse and compare it with period × tick count.

// File: rtl/wait_guard_pkg.sv
package wait_guard_pkg;
    // Number of ETU folded into one tick of the guard.
    parameter int ETU_PER_TICK = 12;
    // Extra bits needed to hold a clocks-per-ETU value multiplied by ETU_PER_TICK.
    parameter int PERIOD_EXTRA_W = 4;
endpackage

// File: rtl/wait_guard_sync.sv
module wait_guard_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic line_fall
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta = line_async;
        s_d.sync = s_q.meta;
        s_d.prev = s_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{meta: 1'b1, sync: 1'b1, prev: 1'b1};
        else        s_q <= s_d;
    end

    assign line_fall = s_q.prev & ~s_q.sync;
endmodule

// File: rtl/wait_guard_cfg.sv
module wait_guard_cfg #(
    parameter int DATA_W  = 16,
    parameter int PER_W   = 20,
    parameter int DEF_ETU = 372,
    parameter int DEF_WT  = 9600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              etu_wr,
    input  logic [DATA_W-1:0] etu_wdata,
    input  logic              wt_wr,
    input  logic [DATA_W-1:0] wt_wdata,
    output logic [PER_W-1:0]  pend_period,
    output logic [DATA_W-1:0] pend_target
);
    import wait_guard_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] etu;
        logic [DATA_W-1:0] wt;
    } cfg_t;

    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (etu_wr) c_d.etu = etu_wdata;
        if (wt_wr)  c_d.wt  = wt_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{etu: DATA_W'(DEF_ETU), wt: DATA_W'(DEF_WT)};
        else        c_q <= c_d;
    end

    // Derived values are offered continuously; the core samples them at a boundary.
    assign pend_period = PER_W'(c_q.etu) * PER_W'(ETU_PER_TICK);
    assign pend_target = c_q.wt / DATA_W'(ETU_PER_TICK);
endmodule

// File: rtl/wait_guard_core.sv
module wait_guard_core #(
    parameter int PER_W   = 20,
    parameter int TGT_W   = 16,
    parameter int RST_PER = 4464,
    parameter int RST_TGT = 800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             card_clk_en,
    input  logic             rearm,
    input  logic [PER_W-1:0] pend_period,
    input  logic [TGT_W-1:0] pend_target,
    output logic             half_pulse,
    output logic             expire_pulse,
    output logic             running,
    output logic             wave_out
);
    typedef struct packed {
        logic [PER_W-1:0] presc;
        logic [TGT_W-1:0] tick;
        logic [PER_W-1:0] per;
        logic [TGT_W-1:0] tgt;
        logic             run;
        logic             half;
        logic             exp;
        logic             wave;
    } core_t;

    core_t g_d, g_q;
    logic [PER_W:0] presc_inc;
    logic [TGT_W:0] tick_inc;
    logic           at_wrap;

    always_comb begin
        presc_inc = {1'b0, g_q.presc} + 1'b1;
        tick_inc  = {1'b0, g_q.tick} + 1'b1;
        at_wrap   = presc_inc >= {1'b0, g_q.per};

        g_d      = g_q;
        g_d.half = 1'b0;
        g_d.exp  = 1'b0;

        if (rearm) begin
            // A start bit overrides anything else on this edge.
            g_d.presc = '0;
            g_d.tick  = '0;
            g_d.run   = 1'b1;
            g_d.wave  = 1'b0;
            g_d.per   = pend_period;
            g_d.tgt   = pend_target;
        end else if (g_q.run && card_clk_en) begin
            if (at_wrap) begin
                g_d.presc = '0;
                g_d.wave  = 1'b0;
                g_d.tick  = tick_inc[TGT_W-1:0];
                g_d.per   = pend_period;
                g_d.tgt   = pend_target;
                // The finished tick is judged against the settings it ran with.
                if (tick_inc >= {1'b0, g_q.tgt}) begin
                    g_d.exp = 1'b1;
                    g_d.run = 1'b0;
                end else if (tick_inc == {2'b00, g_q.tgt[TGT_W-1:1]}) begin
                    g_d.half = 1'b1;
                end
            end else begin
                g_d.presc = presc_inc[PER_W-1:0];
                if (presc_inc == {2'b00, g_q.per[PER_W-1:1]}) g_d.wave = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '{presc: '0, tick: '0, per: PER_W'(RST_PER), tgt: TGT_W'(RST_TGT),
                     run: 1'b1, half: 1'b0, exp: 1'b0, wave: 1'b0};
        end else begin
            g_q <= g_d;
        end
    end

    assign half_pulse   = g_q.half;
    assign expire_pulse = g_q.exp;
    assign running      = g_q.run;
    assign wave_out     = g_q.wave;
endmodule

// File: rtl/wait_guard_top.sv
module wait_guard_top #(
    parameter int DATA_W  = 16,
    parameter int DEF_ETU = 372,
    parameter int DEF_WT  = 9600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_clk_en,
    input  logic              io_line,
    input  logic              etu_wr,
    input  logic [DATA_W-1:0] etu_wdata,
    input  logic              wt_wr,
    input  logic [DATA_W-1:0] wt_wdata,
    output logic              half_pulse,
    output logic              expire_pulse,
    output logic              running,
    output logic              wave_out
);
    import wait_guard_pkg::*;

    localparam int PER_W = DATA_W + PERIOD_EXTRA_W;

    logic              io_fall;
    logic [PER_W-1:0]  pend_period;
    logic [DATA_W-1:0] pend_target;

    wait_guard_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_async (io_line),
        .line_fall  (io_fall)
    );

    wait_guard_cfg #(
        .DATA_W (DATA_W), .PER_W (PER_W), .DEF_ETU (DEF_ETU), .DEF_WT (DEF_WT)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .etu_wr      (etu_wr),
        .etu_wdata   (etu_wdata),
        .wt_wr       (wt_wr),
        .wt_wdata    (wt_wdata),
        .pend_period (pend_period),
        .pend_target (pend_target)
    );

    wait_guard_core #(
        .PER_W   (PER_W),
        .TGT_W   (DATA_W),
        .RST_PER (DEF_ETU * ETU_PER_TICK),
        .RST_TGT (DEF_WT / ETU_PER_TICK)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .card_clk_en  (card_clk_en),
        .rearm        (io_fall),
        .pend_period  (pend_period),
        .pend_target  (pend_target),
        .half_pulse   (half_pulse),
        .expire_pulse (expire_pulse),
        .running      (running),
        .wave_out     (wave_out)
    );
endmodule

// File: rtl/wait_guard_checker.sv
module wait_guard_checker (
    input logic clk,
    input logic rst_n,
    input logic half_pulse,
    input logic expire_pulse,
    input logic running,
    input logic wave_out,
    input logic rearm
);
    assert_pulses_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(half_pulse && expire_pulse));

    assert_half_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        half_pulse |=> !half_pulse);

    assert_expire_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        expire_pulse |-> !running);

    assert_expire_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        expire_pulse |=> !expire_pulse);

    assert_stop_only_on_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> expire_pulse);

    assert_silent_when_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && $past(!running)) |-> (!half_pulse && !expire_pulse));

    assert_rearm_by_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(rearm));

    assert_wave_low_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !wave_out);
endmodule

bind wait_guard_top wait_guard_checker u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .half_pulse   (half_pulse),
    .expire_pulse (expire_pulse),
    .running      (running),
    .wave_out     (wave_out),
    .rearm        (io_fall)
);

// File: tb/tb_wait_guard_top.sv
module tb_wait_guard_top;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic card_clk_en = 1'b0;
    logic io_line = 1'b1;
    logic etu_wr = 1'b0;
    logic [DW-1:0] etu_wdata = '0;
    logic wt_wr = 1'b0;
    logic [DW-1:0] wt_wdata = '0;
    logic half_pulse, expire_pulse, running, wave_out;

    always #2 clk = ~clk;

    wait_guard_top dut (
        .clk (clk), .rst_n (rst_n), .card_clk_en (card_clk_en), .io_line (io_line),
        .etu_wr (etu_wr), .etu_wdata (etu_wdata), .wt_wr (wt_wr), .wt_wdata (wt_wdata),
        .half_pulse (half_pulse), .expire_pulse (expire_pulse),
        .running (running), .wave_out (wave_out)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    string tag = "R1";

    // Reference model state, built from the requirements.
    int m_cfg_etu = 372, m_cfg_wt = 9600;
    int m_per = 372 * 12, m_tgt = 9600 / 12;
    int m_presc = 0, m_tick = 0;
    bit m_run = 1, m_half = 0, m_exp = 0, m_wave = 0;
    bit m_meta = 1, m_sync = 1, m_prev = 1;
    int since_arm = 0, half_at = -1, exp_at = -1;

    function automatic int f_period(int etu); return etu * 12; endfunction
    function automatic int f_target(int wt);  return wt / 12;  endfunction

    task automatic check(bit act, bit exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_int(int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        bit fall;
        int ninc;
        fall = m_prev && !m_sync;
        m_half = 0; m_exp = 0;
        if (fall) begin
            m_presc = 0; m_tick = 0; m_run = 1; m_wave = 0;
            m_per = f_period(m_cfg_etu); m_tgt = f_target(m_cfg_wt);
            since_arm = 0; half_at = -1; exp_at = -1;
        end else if (m_run && card_clk_en) begin
            since_arm++;
            ninc = m_presc + 1;
            if (ninc >= m_per) begin
                m_presc = 0; m_wave = 0; m_tick++;
                if (m_tick >= m_tgt) begin m_exp = 1; m_run = 0; end
                else if (m_tick == m_tgt / 2) m_half = 1;
                m_per = f_period(m_cfg_etu); m_tgt = f_target(m_cfg_wt);
            end else begin
                m_presc = ninc;
                if (ninc == m_per / 2) m_wave = 1;
            end
        end
        m_prev = m_sync; m_sync = m_meta; m_meta = io_line;
        if (etu_wr) m_cfg_etu = int'(etu_wdata);
        if (wt_wr)  m_cfg_wt  = int'(wt_wdata);
    endtask

    // One clock: inputs are already driven; model updates at the edge, outputs compared at the falling edge.
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (half_pulse === 1'b1 && half_at < 0) half_at = since_arm;
        if (expire_pulse === 1'b1 && exp_at < 0) exp_at = since_arm;
        check(half_pulse, m_half, "half_pulse");
        check(expire_pulse, m_exp, "expire_pulse");
        check(running, m_run, "running");
        check(wave_out, m_wave, "wave_out");
    endtask

    task automatic write_cfg(int etu, int wt);
        etu_wr = 1; etu_wdata = DW'(etu); wt_wr = 1; wt_wdata = DW'(wt);
        step();
        etu_wr = 0; wt_wr = 0;
    endtask

    task automatic arm();
        io_line = 0;
        repeat (3) step();
        io_line = 1;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired during %s", tag);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state, then the reset-default period (wave rises at 2232).
        tag = "R1";
        check(running, 1'b1, "running after reset");
        check(half_pulse, 1'b0, "half after reset");
        check(expire_pulse, 1'b0, "expire after reset");
        check(wave_out, 1'b0, "wave after reset");
        card_clk_en = 1;
        run(2300);
        check(wave_out, 1'b1, "wave after half of default period");

        // R2/R3/R4: period 12, target 5, half at tick 2.
        tag = "R3";
        write_cfg(1, 60);
        arm();
        run(80);
        check_int(half_at, 24, "R4 half pulse distance");
        check_int(exp_at, 60, "R3 expiry distance");

        // R2: gated card clock doubles the distance.
        tag = "R2";
        write_cfg(1, 24);
        arm();
        for (int i = 0; i < 60; i++) begin card_clk_en = i[0]; step(); end
        check_int(exp_at, 24, "R2 enabled cycles to expiry");
        card_clk_en = 1;

        // R8: target zero and one.
        tag = "R8";
        write_cfg(1, 11);
        arm();
        run(20);
        check_int(exp_at, 12, "R8 zero target expiry");
        check_int(half_at, -1, "R8 no half pulse");
        write_cfg(1, 12);
        arm();
        run(20);
        check_int(exp_at, 12, "R8 target one expiry");

        // R6/R5: stays stopped; a rising edge does nothing; a falling edge re-arms.
        tag = "R6";
        io_line = 0; run(2);
        tag = "R5";
        io_line = 1; run(40);
        check(running, 1'b0, "R5 rising edge ignored");
        arm();
        check(running, 1'b1, "R5 rearm after falling edge");
        run(20);

        // R7: mid-count write applies at the next boundary.
        tag = "R7";
        write_cfg(1, 120);
        arm();
        run(15);
        write_cfg(2, 36);
        run(60);
        check_int(exp_at, 48, "R7 deferred configuration");

        // R10: re-arm lands on the tick boundary of a one-tick target.
        tag = "R10";
        write_cfg(1, 12);
        arm();
        while (!(m_run && m_presc == m_per - 3)) step();
        arm();
        check(running, 1'b1, "R10 rearm wins");
        check_int(exp_at, -1, "R10 no expiry on coincident edge");
        run(20);

        // R9 plus random mix of everything.
        tag = "R9";
        for (int t = 0; t < 200; t++) begin
            write_cfg(1 + int'($urandom_range(0, 2)), int'($urandom_range(0, 72)));
            arm();
            for (int c = 0; c < int'($urandom_range(60, 300)); c++) begin
                card_clk_en = ($urandom_range(0, 3) != 0);
                if ($urandom_range(0, 99) == 0) io_line = 0;
                else if ($urandom_range(0, 3) == 0) io_line = 1;
                if ($urandom_range(0, 149) == 0) begin
                    etu_wr = 1; etu_wdata = DW'($urandom_range(1, 3));
                end
                if ($urandom_range(0, 149) == 0) begin
                    wt_wr = 1; wt_wdata = DW'($urandom_range(0, 72));
                end
                step();
                etu_wr = 0; wt_wr = 0;
            end
            io_line = 1; card_clk_en = 1;
            run(4);
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule